// File: doc/BRIEF.md
# Shader Source Operand Fetch with Relative Constant Addressing

This block is the operand-fetch stage for one source operand of a vertex shader pipeline. A 7-bit source number arrives together with a 2-bit offset selector. The block works out which register file the number names: input attributes, temporaries or float constants. Input and temporary reads go out through a narrow external read port. Constant reads come from a local bank of 96 four-component vectors that the host fills through a write port.

Constant operands can be offset by one of three signed address values: two general address registers and a loop counter. The offset is accepted only when it fits in a signed byte. It is added to the constant index and the sum wraps to 7 bits. Any effective index that lands past the last constant returns a vector of four 1.0 values in the 24-bit shader float format. The fetched vector appears one cycle after the request, with a valid flag.

Top module: `shader_src_fetch`

## Requirements
- R1: Source numbers 0x00-0x0F read input attribute n through the external port with `ext_rd_tmp`=0 and `ext_rd_idx`=n. Numbers 0x10-0x1F read temporary n-0x10 with `ext_rd_tmp`=1. Numbers 0x20-0x7F name constant n-0x20.
- R2: `rd_valid` is high in the cycle after a cycle with `rd_req` high, and `rd_data` holds the fetched vector in that cycle. When `rd_valid` is low, `rd_data` is zero.
- R3: `rd_idx_sel` picks the offset source: 0 no offset, 1 `addr_x`, 2 `addr_y`, 3 `loop_ctr`.
- R4: For input and temporary operands the offset is ignored, and the data returned is exactly the external port data.
- R5: A selected offset below -128 or above 127 (as a signed 32-bit value) is treated as zero.
- R6: The effective constant index is (n-0x20 + offset) AND 0x7F, with negative offsets in two's complement.
- R7: An effective index above 95 returns 0x3F0000 in every 24-bit component, which is 1.0 in the shader float format. Component 0 sits in bits 23:0.
- R8: A host write with `wr_en` high stores `wr_data` at index `wr_idx` when `wr_idx` is 0..95. A write with `wr_idx` of 96..127 changes no constant.
- R9: When a constant read and a host write target the same index in one cycle, the read returns the previous contents. The next read returns the new vector.
- R10: After reset, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Fetch request |
| rd_src | input | 7 | Source register number |
| rd_idx_sel | input | 2 | Offset source selector |
| addr_x | input | 32 | First address register, signed |
| addr_y | input | 32 | Second address register, signed |
| loop_ctr | input | 32 | Loop counter, signed |
| ext_rd_tmp | output | 1 | External file select: 0 input, 1 temporary |
| ext_rd_idx | output | 4 | External register index |
| ext_rd_data | input | 96 | External read data, same cycle |
| wr_en | input | 1 | Host constant write strobe |
| wr_idx | input | 7 | Host write index |
| wr_data | input | 96 | Host write vector |
| rd_valid | output | 1 | Result valid |
| rd_data | output | 96 | Fetched vector |

## Verification
The embedded properties check, on every cycle, that a request yields exactly one valid result one cycle later, that idle cycles return a zero vector, and that input and temporary operands pass the external data through unchanged whatever offset is selected. One wrap case is also watched continuously: the top constant plus one returns the all-ones vector. Index arithmetic only shows up in the bench's scenarios against a model of the bank's contents. These scenarios cover byte-range rejection, 7-bit wraparound, negative offsets, the choice of offset source, dropped writes above index 95, and old data returned on a same-cycle read and write.

// File: rtl/srcfetch_pkg.sv
package srcfetch_pkg;

    localparam int COMP_W     = 24;
    localparam int SRC_W      = 7;
    localparam int EXT_IDX_W  = 4;
    localparam logic [SRC_W-1:0] TMP_BASE   = 7'h10;
    localparam logic [SRC_W-1:0] CONST_BASE = 7'h20;
    localparam logic [COMP_W-1:0] F24_ONE   = 24'h3F0000;

    typedef enum logic [1:0] {
        SRC_INPUT = 2'd0,
        SRC_TEMP  = 2'd1,
        SRC_CONST = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        OFS_NONE = 2'd0,
        OFS_AX   = 2'd1,
        OFS_AY   = 2'd2,
        OFS_LOOP = 2'd3
    } ofs_sel_e;

endpackage

// File: rtl/src_decode.sv
module src_decode
    import srcfetch_pkg::*;
(
    input  logic [SRC_W-1:0]     src,
    output src_kind_e            kind,
    output logic [EXT_IDX_W-1:0] ext_idx,
    output logic [SRC_W-1:0]     const_idx
);

    always_comb begin
        ext_idx   = src[EXT_IDX_W-1:0];
        const_idx = '0;
        if (src >= CONST_BASE) begin
            kind      = SRC_CONST;
            const_idx = src - CONST_BASE;
        end else if (src >= TMP_BASE) begin
            kind = SRC_TEMP;
        end else begin
            kind = SRC_INPUT;
        end
    end

endmodule

// File: rtl/ofs_pick.sv
module ofs_pick
    import srcfetch_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  logic [1:0]              sel,
    input  logic signed [OFS_W-1:0] ax,
    input  logic signed [OFS_W-1:0] ay,
    input  logic signed [OFS_W-1:0] al,
    output logic [7:0]              ofs
);

    localparam logic signed [OFS_W-1:0] BYTE_MIN = -128;
    localparam logic signed [OFS_W-1:0] BYTE_MAX = 127;

    logic signed [OFS_W-1:0] chosen;

    always_comb begin
        unique case (ofs_sel_e'(sel))
            OFS_AX:   chosen = ax;
            OFS_AY:   chosen = ay;
            OFS_LOOP: chosen = al;
            default:  chosen = '0;
        endcase
        if (chosen < BYTE_MIN || chosen > BYTE_MAX)
            ofs = '0;
        else
            ofs = chosen[7:0];
    end

endmodule

// File: rtl/const_bank.sv
module const_bank
    import srcfetch_pkg::*;
#(
    parameter int VEC_W     = 96,
    parameter int NUM_CONST = 96,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);

    localparam int NCOMP = VEC_W / COMP_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CONST - 1);
    localparam logic [VEC_W-1:0] ONES_VEC = {NCOMP{F24_ONE}};

    typedef struct packed {
        logic [VEC_W-1:0] data;
        logic             oob;
    } bank_st_t;

    logic [VEC_W-1:0] mem [NUM_CONST];
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (rd_idx > LAST_IDX) begin
                st_d.oob  = 1'b1;
                st_d.data = '0;
            end else begin
                st_d.oob  = 1'b0;
                st_d.data = mem[rd_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_idx <= LAST_IDX)
            mem[wr_idx] <= wr_data;
    end

    assign rd_vec = st_q.oob ? ONES_VEC : st_q.data;

endmodule

// File: rtl/shader_src_fetch.sv
module shader_src_fetch
    import srcfetch_pkg::*;
#(
    parameter int VEC_W     = 96,
    parameter int NUM_CONST = 96,
    parameter int OFS_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req,
    input  logic [6:0]              rd_src,
    input  logic [1:0]              rd_idx_sel,
    input  logic signed [OFS_W-1:0] addr_x,
    input  logic signed [OFS_W-1:0] addr_y,
    input  logic signed [OFS_W-1:0] loop_ctr,
    output logic                    ext_rd_tmp,
    output logic [3:0]              ext_rd_idx,
    input  logic [VEC_W-1:0]        ext_rd_data,
    input  logic                    wr_en,
    input  logic [6:0]              wr_idx,
    input  logic [VEC_W-1:0]        wr_data,
    output logic                    rd_valid,
    output logic [VEC_W-1:0]        rd_data
);

    localparam int NCOMP = VEC_W / COMP_W;
    localparam logic [VEC_W-1:0] ONES_VEC = {NCOMP{F24_ONE}};

    typedef struct packed {
        logic             valid;
        src_kind_e        kind;
        logic [VEC_W-1:0] ext_data;
    } pipe_t;

    src_kind_e        dec_kind;
    logic [3:0]       dec_ext_idx;
    logic [6:0]       dec_const_idx;
    logic [7:0]       ofs;
    logic [6:0]       eff_idx;
    logic             bank_rd;
    logic [VEC_W-1:0] bank_vec;
    pipe_t            p_d, p_q;

    src_decode u_dec (
        .src       (rd_src),
        .kind      (dec_kind),
        .ext_idx   (dec_ext_idx),
        .const_idx (dec_const_idx)
    );

    ofs_pick #(.OFS_W(OFS_W)) u_ofs (
        .sel (rd_idx_sel),
        .ax  (addr_x),
        .ay  (addr_y),
        .al  (loop_ctr),
        .ofs (ofs)
    );

    assign eff_idx = dec_const_idx + ofs[6:0];
    assign bank_rd = rd_req && (dec_kind == SRC_CONST);

    const_bank #(.VEC_W(VEC_W), .NUM_CONST(NUM_CONST), .IDX_W(7)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_en   (bank_rd),
        .rd_idx  (eff_idx),
        .rd_vec  (bank_vec)
    );

    assign ext_rd_tmp = (dec_kind == SRC_TEMP);
    assign ext_rd_idx = dec_ext_idx;

    always_comb begin
        p_d       = p_q;
        p_d.valid = rd_req;
        if (rd_req) begin
            p_d.kind = dec_kind;
            if (dec_kind != SRC_CONST) p_d.ext_data = ext_rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_valid = p_q.valid;
    always_comb begin
        if (!p_q.valid)                  rd_data = '0;
        else if (p_q.kind == SRC_CONST)  rd_data = bank_vec;
        else                             rd_data = p_q.ext_data;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);                                                   // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && rd_data == '0));                              // R2
    AST_EXT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_src < 7'h20) |=> rd_data == $past(ext_rd_data));         // R4
    AST_WRAP_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_src == 7'h7F && rd_idx_sel == 2'd1 && addr_x == 1)
        |=> rd_data == ONES_VEC);                                               // R7

endmodule

// File: tb/sim_shader_src_fetch.sv
module sim_shader_src_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_src = '0;
    logic [1:0]  rd_idx_sel = '0;
    logic signed [31:0] addr_x = '0, addr_y = '0, loop_ctr = '0;
    logic        ext_rd_tmp;
    logic [3:0]  ext_rd_idx;
    logic [95:0] ext_rd_data;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [95:0] wr_data = '0;
    logic        rd_valid;
    logic [95:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [95:0] model_c [96];

    localparam logic [95:0] ONES = {4{24'h3F0000}};

    always #5 clk = ~clk;

    shader_src_fetch u0 (.*);

    function automatic logic [95:0] ext_val(input logic tmp, input logic [3:0] idx);
        logic [23:0] b;
        b = (tmp ? 24'hE00000 : 24'hD00000) + 24'(idx);
        return {b + 24'h3000, b + 24'h2000, b + 24'h1000, b};
    endfunction

    function automatic logic [95:0] cval(input int i);
        return {24'h400000 + 24'(i), 24'h300000 + 24'(i), 24'h200000 + 24'(i), 24'h100000 + 24'(i)};
    endfunction

    assign ext_rd_data = ext_val(ext_rd_tmp, ext_rd_idx);

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic host_wr(input logic [6:0] idx, input logic [95:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        if (idx < 7'd96) model_c[idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_regs(input logic [1:0] sel, input logic signed [31:0] v);
        addr_x = (sel == 2'd0) ? 32'sd7 : 32'sd5;
        addr_y = addr_x;
        loop_ctr = addr_x;
        case (sel)
            2'd1: addr_x = v;
            2'd2: addr_y = v;
            2'd3: loop_ctr = v;
            default: ;
        endcase
    endtask

    // returns the result in the cycle after the request
    task automatic do_read(input logic [6:0] src, input logic [1:0] sel,
                           input logic signed [31:0] v, output logic [95:0] res,
                           output logic vld);
        @(negedge clk);
        rd_req = 1'b1; rd_src = src; rd_idx_sel = sel;
        set_regs(sel, v);
        @(negedge clk);
        rd_req = 1'b0;
        res = rd_data;
        vld = rd_valid;
    endtask

    // entry: {src, sel, offset, expect}; expect[8:7]: 0 const idx, 1 ones, 2 input, 3 temp
    localparam int NV = 18;
    localparam logic [49:0] VEC [NV] = '{
        {7'h03, 2'd0, 32'h0000_0000, 9'h103},
        {7'h0F, 2'd1, 32'h0000_0004, 9'h10F},
        {7'h10, 2'd2, 32'h0000_0009, 9'h180},
        {7'h1F, 2'd3, 32'hFFFF_FFF0, 9'h18F},
        {7'h20, 2'd0, 32'h0000_0000, 9'h000},
        {7'h7F, 2'd0, 32'h0000_0000, 9'h05F},
        {7'h28, 2'd2, 32'h0000_0003, 9'h00B},
        {7'h28, 2'd1, 32'hFFFF_FFFD, 9'h005},
        {7'h2A, 2'd3, 32'h0000_0014, 9'h01E},
        {7'h7F, 2'd1, 32'h0000_0001, 9'h080},
        {7'h20, 2'd2, 32'hFFFF_FFFF, 9'h080},
        {7'h7A, 2'd1, 32'h0000_007F, 9'h059},
        {7'h25, 2'd3, 32'h0000_0080, 9'h005},
        {7'h25, 2'd1, 32'hFFFF_FF7F, 9'h005},
        {7'h2A, 2'd2, 32'hFFFF_FF9C, 9'h026},
        {7'h48, 2'd3, 32'hFFFF_FFD7, 9'h080},
        {7'h23, 2'd1, 32'h7FFF_FFFF, 9'h003},
        {7'h52, 2'd2, 32'h0000_003C, 9'h080}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [95:0] res, exp;
        logic vld;
        repeat (3) @(negedge clk);
        chk("R10 valid after reset", {95'b0, rd_valid}, 96'b0);
        chk("R10 data after reset", rd_data, '0);
        rst_n = 1'b1;

        for (int i = 0; i < 96; i++) host_wr(7'(i), cval(i));

        // table walk: R1 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            logic [8:0] e;
            e = VEC[k][8:0];
            do_read(VEC[k][49:43], VEC[k][42:41], VEC[k][40:9], res, vld);
            case (e[8:7])
                2'd0: exp = model_c[e[6:0]];
                2'd1: exp = ONES;
                2'd2: exp = ext_val(1'b0, e[3:0]);
                default: exp = ext_val(1'b1, e[3:0]);
            endcase
            chk($sformatf("R1/R3/R4/R5/R6/R7 vector %0d", k), res, exp);
            chk("R2 valid one cycle after request", {95'b0, vld}, 96'd1);
        end

        // R2: idle cycle after a read
        @(negedge clk);
        chk("R2 idle valid low", {95'b0, rd_valid}, 96'b0);
        chk("R2 idle data zero", rd_data, '0);

        // R8: writes above 95 are dropped
        host_wr(7'd96, {4{24'hBADBAD}});
        host_wr(7'd100, {4{24'hBADBAD}});
        host_wr(7'd127, {4{24'hBADBAD}});
        do_read(7'h20, 2'd0, 0, res, vld);
        chk("R8 c0 untouched", res, cval(0));
        do_read(7'h24, 2'd0, 0, res, vld);
        chk("R8 c4 untouched", res, cval(4));
        do_read(7'h3F, 2'd0, 0, res, vld);
        chk("R8 c31 untouched", res, cval(31));
        do_read(7'h7F, 2'd0, 0, res, vld);
        chk("R8 c95 untouched", res, cval(95));
        host_wr(7'd20, {4{24'h0A0B0C}});
        do_read(7'h34, 2'd0, 0, res, vld);
        chk("R8 write to c20 visible", res, {4{24'h0A0B0C}});

        // R9: same-cycle read and write of c30 (via c26 + 4)
        @(negedge clk);
        rd_req = 1'b1; rd_src = 7'h3A; rd_idx_sel = 2'd1; set_regs(2'd1, 4);
        wr_en = 1'b1; wr_idx = 7'd30; wr_data = {4{24'h777777}};
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b0;
        chk("R9 same-cycle read gives old data", rd_data, cval(30));
        do_read(7'h3E, 2'd0, 0, res, vld);
        chk("R9 following read gives new data", res, {4{24'h777777}});

        finish_run();
    end

endmodule